// File: doc/BRIEF.md
# External Cache Error Trap Control

This block is the per-core error controller that sits between an external cache, the system bus and the core's trap logic. Software programs a small enable register. Three of its bits gate the trap classes. Two groups of fields let a test override the ECC check bits that the cache's ECC generator writes, separately for data words and for memory tags.

Each error event comes with four things: a severity, the operation that caused it, a sub-kind for interrupt vector fetches, and a flag that tells whether the error was seen on the system bus or in a local cache read. The block turns each event into at most one trap request. There are four trap types: a fast cache-ECC trap, an instruction-access fault, a data-access fault and a disrupting ECC trap. The same event always sets a sticky bit in a fault status register, even when the matching trap is disabled. Software clears status bits by writing 1 to them.

Error events are plain control inputs. One event can be presented on each cycle that `err_valid` is high. There is no back-pressure, and every valid event is taken in the cycle it is presented.

Top module: `ecache_err_ctl`

## Requirements
- R1: After reset, the enable register reads 0, the status register reads 0 and all four trap outputs are low.
- R2: A write loads the enable register, and bit 2 always reads 0. Bit 0 enables corrected-error traps, bit 1 enables uncorrectable and system traps, and bit 3 enables the fast trap. Bits 12:4 hold the forced data check value and bit 13 forces it. Bits 17:14 hold the forced tag check value and bit 18 forces it. An event in the same cycle as a write is classified with the value held before that write.
- R3: The fast trap is raised only for a local cache read (`err_from_bus`=0). The operation must be load (op 0), instruction fetch (op 1) or atomic (op 2). The severity must be software-correctable (sev 1) or uncorrectable (sev 2). Enable bit 3 must be set. Store merge (op 3), writeback (op 4) and copyout (op 5) never raise the fast trap.
- R4: With enable bit 1 set, an uncorrectable-class error that does not take the fast path raises a trap chosen by its operation. The uncorrectable class is sev 2, bus error (sev 3) and timeout (sev 4). An instruction fetch raises the instruction-access fault. A load or atomic raises the data-access fault.
- R5: With enable bit 1 set, an uncorrectable-class error from store merge, writeback or copyout raises the disrupting trap.
- R6: With enable bit 0 set, a hardware-corrected error (sev 0) raises the disrupting trap if it was seen on the bus or came from merge, writeback or copyout. A corrected error on a local cache read of a load, fetch or atomic raises no trap.
- R7: An uncorrectable-class error from an interrupt vector fetch (op 6) is routed by `err_ivkind`. Kind 0 raises the instruction-access fault, kind 1 raises the data-access fault, and kind 2 or 3 raises the disrupting trap.
- R8: Every valid event sets one status bit, with or without its trap enable. Bit 0 is hardware-corrected. Bit 1 is software-correctable. Bit 2 is an uncorrectable error on the fast path. Bit 3 is any other uncorrectable error. Bit 4 is a bus error. Bit 5 is a timeout.
- R9: Status bits stay set until software clears them by writing 1 to them. If hardware sets a bit in the same cycle that software clears it, the set wins.
- R10: A trap output is a one-cycle pulse in the cycle after the event, and at most one trap output is high at a time.
- R11: While bit 13 is set, the data check output carries bits 12:4. Otherwise it passes the generator's data check bits unchanged. The tag check output behaves the same way, using bit 18 and bits 17:14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Enable register write strobe |
| cfg_wdata | input | 19 | Enable register write data |
| cfg_rdata | output | 19 | Enable register contents |
| st_clr_en | input | 1 | Status clear strobe |
| st_clr_mask | input | 6 | Status bits to clear (write 1 to clear) |
| st_flags | output | 6 | Sticky fault status |
| err_valid | input | 1 | Error event present this cycle |
| err_sev | input | 3 | Severity code |
| err_op | input | 3 | Originating operation code |
| err_ivkind | input | 2 | Sub-kind for interrupt vector fetch |
| err_from_bus | input | 1 | 1 = seen on the system bus, 0 = local cache read |
| gen_data_chk | input | 9 | Data check bits from the ECC generator |
| gen_tag_chk | input | 4 | Tag check bits from the ECC generator |
| ecc_data_chk | output | 9 | Data check bits sent to storage |
| ecc_tag_chk | output | 4 | Tag check bits sent to storage |
| trap_fast | output | 1 | Fast cache-ECC trap request |
| trap_iacc | output | 1 | Instruction-access fault request |
| trap_dacc | output | 1 | Data-access fault request |
| trap_disr | output | 1 | Disrupting ECC trap request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a hardware status set and a software clear. The bench raises a bus error and a corrected error in turn, then presents another corrected error in the same cycle as a clear of all bits. It expects the corrected-error bit to survive and the bus-error bit to drop.

The second pair is an enable register write and an error event. The bench writes zero to the enable register in the same cycle as a fast-trap event. It expects the trap to fire under the old enable value, and a repeat of the event to raise nothing.

// File: rtl/ecerr_pkg.sv
package ecerr_pkg;

  typedef enum logic [2:0] {
    SEV_HWCORR  = 3'd0,
    SEV_SWCORR  = 3'd1,
    SEV_UNCORR  = 3'd2,
    SEV_BUSERR  = 3'd3,
    SEV_TIMEOUT = 3'd4
  } sev_e;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_IFETCH  = 3'd1,
    OP_ATOMIC  = 3'd2,
    OP_MERGE   = 3'd3,
    OP_WRBACK  = 3'd4,
    OP_COPYOUT = 3'd5,
    OP_IVEC    = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    IVK_FETCH = 2'd0,
    IVK_LOAD  = 2'd1,
    IVK_BG    = 2'd2
  } ivk_e;

  // enable register trap bits (software-visible positions)
  localparam int EN_CE     = 0;
  localparam int EN_UC     = 1;
  localparam int EN_RSVD   = 2;
  localparam int EN_FAST   = 3;
  localparam int DCHK_LSB  = 4;

  // status register
  localparam int ST_W    = 6;
  localparam int ST_CE   = 0;
  localparam int ST_SWC  = 1;
  localparam int ST_UCL  = 2;
  localparam int ST_UE   = 3;
  localparam int ST_BERR = 4;
  localparam int ST_TO   = 5;

  typedef struct packed {
    logic fast;
    logic iacc;
    logic dacc;
    logic disr;
  } trap_t;

endpackage

// File: rtl/ecerr_cfg.sv
module ecerr_cfg
  import ecerr_pkg::*;
#(
  parameter int DCHK_W = 9,
  parameter int TCHK_W = 4,
  localparam int DFORCE   = DCHK_LSB + DCHK_W,
  localparam int TCHK_LSB = DFORCE + 1,
  localparam int TFORCE   = TCHK_LSB + TCHK_W,
  localparam int CFG_W    = TFORCE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  cfg_q,
  input  logic [DCHK_W-1:0] gen_data_chk,
  input  logic [TCHK_W-1:0] gen_tag_chk,
  output logic [DCHK_W-1:0] out_data_chk,
  output logic [TCHK_W-1:0] out_tag_chk
);

  localparam logic [CFG_W-1:0] WMASK = ~(CFG_W'(1) << EN_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wdata & WMASK;
  end

  always_comb begin
    out_data_chk = gen_data_chk;
    out_tag_chk  = gen_tag_chk;
    if (cfg_q[DFORCE]) out_data_chk = cfg_q[DFORCE-1:DCHK_LSB];
    if (cfg_q[TFORCE]) out_tag_chk  = cfg_q[TFORCE-1:TCHK_LSB];
  end

  // R2: the unused bit never holds a one after a write
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !cfg_q[EN_RSVD]);

endmodule

// File: rtl/ecerr_classify.sv
module ecerr_classify
  import ecerr_pkg::*;
(
  input  logic            ev_valid,
  input  logic [2:0]      ev_sev,
  input  logic [2:0]      ev_op,
  input  logic [1:0]      ev_kind,
  input  logic            ev_bus,
  input  logic            en_ce,
  input  logic            en_uc,
  input  logic            en_fast,
  output trap_t           trap_d,
  output logic [ST_W-1:0] st_set
);

  sev_e  sev;
  op_e   op;
  logic  local_rd;
  logic  bkg_op;
  trap_t uc_route;

  always_comb begin
    sev      = sev_e'(ev_sev);
    op       = op_e'(ev_op);
    local_rd = !ev_bus && (op == OP_LOAD || op == OP_IFETCH || op == OP_ATOMIC);
    bkg_op   = (op == OP_MERGE || op == OP_WRBACK || op == OP_COPYOUT);
  end

  // destination for uncorrectable-class errors, by operation
  always_comb begin
    uc_route = '0;
    case (op)
      OP_IFETCH:           uc_route.iacc = 1'b1;
      OP_LOAD, OP_ATOMIC:  uc_route.dacc = 1'b1;
      OP_IVEC: begin
        case (ivk_e'(ev_kind))
          IVK_FETCH: uc_route.iacc = 1'b1;
          IVK_LOAD:  uc_route.dacc = 1'b1;
          default:   uc_route.disr = 1'b1;
        endcase
      end
      default:             uc_route.disr = 1'b1;
    endcase
  end

  always_comb begin
    trap_d = '0;
    st_set = '0;
    if (ev_valid) begin
      case (sev)
        SEV_HWCORR: begin
          st_set[ST_CE] = 1'b1;
          trap_d.disr   = en_ce && (ev_bus || bkg_op);
        end
        SEV_SWCORR: begin
          st_set[ST_SWC] = 1'b1;
          trap_d.fast    = en_fast && local_rd;
        end
        SEV_UNCORR: begin
          if (local_rd) begin
            st_set[ST_UCL] = 1'b1;
            trap_d.fast    = en_fast;
          end else begin
            st_set[ST_UE] = 1'b1;
            if (en_uc) trap_d = uc_route;
          end
        end
        SEV_BUSERR: begin
          st_set[ST_BERR] = 1'b1;
          if (en_uc) trap_d = uc_route;
        end
        SEV_TIMEOUT: begin
          st_set[ST_TO] = 1'b1;
          if (en_uc) trap_d = uc_route;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ecerr_status.sv
module ecerr_status
  import ecerr_pkg::*;
#(
  parameter int W = ST_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end

  // R9: a set bit survives unless cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~clr) != '0) |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));
  // R9: set wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set & clr) != '0) |=> ((q & $past(set & clr)) == $past(set & clr)));

endmodule

// File: rtl/ecache_err_ctl.sv
module ecache_err_ctl
  import ecerr_pkg::*;
#(
  parameter int DCHK_W = 9,
  parameter int TCHK_W = 4,
  localparam int CFG_W = DCHK_LSB + DCHK_W + 1 + TCHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              st_clr_en,
  input  logic [ST_W-1:0]   st_clr_mask,
  output logic [ST_W-1:0]   st_flags,
  input  logic              err_valid,
  input  logic [2:0]        err_sev,
  input  logic [2:0]        err_op,
  input  logic [1:0]        err_ivkind,
  input  logic              err_from_bus,
  input  logic [DCHK_W-1:0] gen_data_chk,
  input  logic [TCHK_W-1:0] gen_tag_chk,
  output logic [DCHK_W-1:0] ecc_data_chk,
  output logic [TCHK_W-1:0] ecc_tag_chk,
  output logic              trap_fast,
  output logic              trap_iacc,
  output logic              trap_dacc,
  output logic              trap_disr
);

  logic [CFG_W-1:0] cfg_q;
  trap_t            trap_d;
  trap_t            trap_q;
  logic [ST_W-1:0]  st_set;
  logic [ST_W-1:0]  st_clr;

  ecerr_cfg #(.DCHK_W(DCHK_W), .TCHK_W(TCHK_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wdata        (cfg_wdata),
    .cfg_q        (cfg_q),
    .gen_data_chk (gen_data_chk),
    .gen_tag_chk  (gen_tag_chk),
    .out_data_chk (ecc_data_chk),
    .out_tag_chk  (ecc_tag_chk)
  );

  ecerr_classify u_cls (
    .ev_valid (err_valid),
    .ev_sev   (err_sev),
    .ev_op    (err_op),
    .ev_kind  (err_ivkind),
    .ev_bus   (err_from_bus),
    .en_ce    (cfg_q[EN_CE]),
    .en_uc    (cfg_q[EN_UC]),
    .en_fast  (cfg_q[EN_FAST]),
    .trap_d   (trap_d),
    .st_set   (st_set)
  );

  assign st_clr = st_clr_en ? st_clr_mask : '0;

  ecerr_status #(.W(ST_W)) u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (st_set),
    .clr   (st_clr),
    .q     (st_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= '0;
    else        trap_q <= trap_d;
  end

  assign cfg_rdata = cfg_q;
  assign trap_fast = trap_q.fast;
  assign trap_iacc = trap_q.iacc;
  assign trap_dacc = trap_q.dacc;
  assign trap_disr = trap_q.disr;

  // R10: never two trap types at once
  a_r10_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_fast, trap_iacc, trap_dacc, trap_disr}));
  // R10: a trap follows a presented event by one cycle
  a_r10_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fast || trap_iacc || trap_dacc || trap_disr) |-> $past(err_valid));
  // R3: fast trap only for local reads with its enable set
  a_r3_fast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fast |-> ($past(cfg_q[EN_FAST]) && !$past(err_from_bus)));
  // R4: access faults need the uncorrectable enable
  a_r4_access_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_iacc || trap_dacc) |-> $past(cfg_q[EN_UC]));
  // R8: every valid event leaves a status bit set
  a_r8_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_sev <= 3'd4) |=> (st_flags != '0));

endmodule

// File: tb/ecache_err_ctl_bench.sv
module ecache_err_ctl_bench;
  import ecerr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 19;
  localparam int VW = 23;
  localparam int NV = 20;

  // {en[3:0], bus, sev, op, kind, exp {fast,iacc,dacc,disr}, exp status}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b1011, 1'b0, 3'd1, 3'd0, 2'd0, 4'b1000, 6'b000010}, // R3 sw-corr load
    {4'b1011, 1'b0, 3'd2, 3'd1, 2'd0, 4'b1000, 6'b000100}, // R3 uncorr fetch
    {4'b1011, 1'b0, 3'd2, 3'd2, 2'd0, 4'b1000, 6'b000100}, // R3 uncorr atomic
    {4'b0011, 1'b0, 3'd2, 3'd0, 2'd0, 4'b0000, 6'b000100}, // R3 R8 disabled
    {4'b1011, 1'b0, 3'd1, 3'd3, 2'd0, 4'b0000, 6'b000010}, // R3 merge no fast
    {4'b1011, 1'b0, 3'd2, 3'd4, 2'd0, 4'b0001, 6'b001000}, // R5 writeback
    {4'b1011, 1'b1, 3'd2, 3'd1, 2'd0, 4'b0100, 6'b001000}, // R4 bus fetch
    {4'b1011, 1'b1, 3'd2, 3'd0, 2'd0, 4'b0010, 6'b001000}, // R4 bus load
    {4'b1011, 1'b1, 3'd3, 3'd2, 2'd0, 4'b0010, 6'b010000}, // R4 berr atomic
    {4'b1011, 1'b1, 3'd4, 3'd5, 2'd0, 4'b0001, 6'b100000}, // R5 timeout copyout
    {4'b1001, 1'b1, 3'd4, 3'd1, 2'd0, 4'b0000, 6'b100000}, // R4 R8 disabled
    {4'b1011, 1'b1, 3'd0, 3'd0, 2'd0, 4'b0001, 6'b000001}, // R6 bus read
    {4'b1010, 1'b1, 3'd0, 3'd4, 2'd0, 4'b0000, 6'b000001}, // R6 R8 disabled
    {4'b1011, 1'b0, 3'd0, 3'd0, 2'd0, 4'b0000, 6'b000001}, // R6 local read
    {4'b1011, 1'b0, 3'd0, 3'd5, 2'd0, 4'b0001, 6'b000001}, // R6 copyout
    {4'b1011, 1'b1, 3'd2, 3'd6, 2'd0, 4'b0100, 6'b001000}, // R7 kind 0
    {4'b1011, 1'b1, 3'd2, 3'd6, 2'd1, 4'b0010, 6'b001000}, // R7 kind 1
    {4'b1011, 1'b1, 3'd2, 3'd6, 2'd2, 4'b0001, 6'b001000}, // R7 kind 2
    {4'b1011, 1'b1, 3'd3, 3'd6, 2'd1, 4'b0010, 6'b010000}, // R7 berr kind 1
    {4'b1011, 1'b1, 3'd1, 3'd0, 2'd0, 4'b0000, 6'b000010}  // R3 bus sw-corr
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr_en = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic             st_clr_en = 1'b0;
  logic [ST_W-1:0]  st_clr_mask = '0;
  logic [ST_W-1:0]  st_flags;
  logic             err_valid = 1'b0;
  logic [2:0]       err_sev = '0;
  logic [2:0]       err_op = '0;
  logic [1:0]       err_ivkind = '0;
  logic             err_from_bus = 1'b0;
  logic [8:0]       gen_data_chk = 9'h0F0;
  logic [3:0]       gen_tag_chk = 4'h3;
  logic [8:0]       ecc_data_chk;
  logic [3:0]       ecc_tag_chk;
  logic             trap_fast, trap_iacc, trap_dacc, trap_disr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecache_err_ctl u_ecache_err_ctl (.*);

  function automatic logic [3:0] traps();
    return {trap_fast, trap_iacc, trap_dacc, trap_disr};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // write enable register and clear all status in one cycle
  task automatic setup(input logic [CFG_W-1:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = val;
    st_clr_en = 1'b1; st_clr_mask = '1;
    @(negedge clk);
    cfg_wr_en = 1'b0; st_clr_en = 1'b0; st_clr_mask = '0;
  endtask

  task automatic event_drive(input logic bus, input logic [2:0] sev,
                             input logic [2:0] op, input logic [1:0] kind);
    err_valid = 1'b1; err_from_bus = bus; err_sev = sev; err_op = op; err_ivkind = kind;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", 32'(cfg_rdata), 0);
    check("R1 status", 32'(st_flags), 0);
    check("R1 traps", 32'(traps()), 0);
    rst_n = 1'b1;

    // R2 write and readback, unused bit reads 0
    setup('1);
    check("R2 readback", 32'(cfg_rdata), 32'h7FFFB);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      setup({15'd0, v[22:19]});
      event_drive(v[18], v[17:15], v[14:12], v[11:10]);
      @(negedge clk);
      err_valid = 1'b0;
      check($sformatf("R3-R7 vec %0d trap", i), 32'(traps()), 32'(v[9:6]));
      check($sformatf("R8 vec %0d status", i), 32'(st_flags), 32'(v[5:0]));
      @(negedge clk);
      check($sformatf("R10 vec %0d pulse", i), 32'(traps()), 0);
    end

    // R10 back-to-back events
    setup(19'h0000B);
    event_drive(1'b1, 3'd2, 3'd1, 2'd0);
    @(negedge clk);
    check("R10 first", 32'(traps()), 32'b0100);
    event_drive(1'b1, 3'd2, 3'd0, 2'd0);
    @(negedge clk);
    err_valid = 1'b0;
    check("R10 second", 32'(traps()), 32'b0010);
    @(negedge clk);
    check("R10 idle", 32'(traps()), 0);

    // R9 sticky, set wins over clear
    setup(19'h0000B);
    event_drive(1'b1, 3'd3, 3'd0, 2'd0);
    @(negedge clk);
    event_drive(1'b1, 3'd0, 3'd0, 2'd0);
    @(negedge clk);
    err_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 sticky", 32'(st_flags), 32'b010001);
    event_drive(1'b1, 3'd0, 3'd0, 2'd0);
    st_clr_en = 1'b1; st_clr_mask = '1;
    @(negedge clk);
    err_valid = 1'b0; st_clr_en = 1'b0; st_clr_mask = '0;
    check("R9 set wins", 32'(st_flags), 32'b000001);
    st_clr_en = 1'b1; st_clr_mask = 6'b000001;
    @(negedge clk);
    st_clr_en = 1'b0; st_clr_mask = '0;
    check("R9 w1c", 32'(st_flags), 0);

    // R2 write in the same cycle as an event uses the old value
    setup(19'h0000B);
    cfg_wr_en = 1'b1; cfg_wdata = '0;
    event_drive(1'b0, 3'd1, 3'd0, 2'd0);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R2 old enable", 32'(traps()), 32'b1000);
    check("R2 new value", 32'(cfg_rdata), 0);
    @(negedge clk);
    err_valid = 1'b0;
    check("R2 new enable", 32'(traps()), 0);

    // R11 forced check bits
    setup({1'b1, 4'hC, 1'b1, 9'h1A5, 4'h0});
    check("R11 data forced", 32'(ecc_data_chk), 32'h1A5);
    check("R11 tag forced", 32'(ecc_tag_chk), 32'hC);
    setup({1'b0, 4'hC, 1'b0, 9'h1A5, 4'h0});
    check("R11 data pass", 32'(ecc_data_chk), 32'h0F0);
    check("R11 tag pass", 32'(ecc_tag_chk), 32'h3);
    gen_data_chk = 9'h00F; gen_tag_chk = 4'h9;
    #1;
    check("R11 data follow", 32'(ecc_data_chk), 32'h00F);
    check("R11 tag follow", 32'(ecc_tag_chk), 32'h9);

    // R1 reset again clears everything
    event_drive(1'b1, 3'd4, 3'd1, 2'd0);
    @(negedge clk);
    err_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset status", 32'(st_flags), 0);
    check("R1 re-reset cfg", 32'(cfg_rdata), 0);

    finish_run();
  end

endmodule